// File: doc/BRIEF.md
# Output Compare and PWM Generator with Fault Shutdown

This block drives one compare output from a counter and two compare registers, a primary one and a secondary one. The counter advances on a tick. The tick is either the system clock or one of several one-cycle strobes that arrive from timers outside the block. A mode field selects the output behaviour:

- a single set, a single clear or a repeated toggle when the counter reaches the primary value;
- a single pulse that runs from the primary match to the secondary match;
- edge-aligned PWM, with the secondary register setting the period.

In PWM the compare values are double-buffered and take effect at the period boundary. Three fault inputs can force the PWM output low. Each fault input has its own enable bit and a sticky status flag.

Software reaches the block through a write port and a read port, both flat. A trigger status bit can be set and cleared by software. If the control register selects it, the bit also clears itself when the counter meets the secondary value. An idle input freezes the counter and the output when the control register allows it.

The core is a state machine with these states:

| State | Meaning |
|---|---|
| ST_OFF | counter held at zero, output low |
| ST_ARMED | waiting for the primary match in the set, clear, toggle and pulse modes |
| ST_PULSE | pulse output high |
| ST_DONE | single action finished, output held |
| ST_PWM | PWM running |
| ST_FAULT | PWM forced low by a fault |

The transitions are:

| Transition | Condition |
|---|---|
| RESTART | a change of mode field sends the machine to its entry state and zeroes the counter |
| ARM_HIT | primary match in ST_ARMED: to ST_DONE (set/clear), stay (toggle), to ST_PULSE (pulse) |
| PULSE_END | secondary match in ST_PULSE, to ST_DONE |
| TRIP | an enabled status flag is set in ST_PWM, to ST_FAULT |
| RECOVER | in ST_FAULT, at a period boundary with all enabled flags clear and no enabled fault input active, to ST_PWM |

Top module: `ocpwm_unit`

## Requirements
- R1: After reset every register reads zero and the output is low. Control bits 15:14 always read zero. Address map: 0 control, 1 primary, 2 secondary, 3 trigger status (bit 0), 4 counter.
- R2: Control bits 7:5 select the tick. 111 ticks every clock. Values 0 to 4 use ext_tick[value]. 101 and 110 never tick. Ticks on other ext_tick lines are ignored.
- R3: Idle-stop is control bit 4. With it set and idle_in high, the counter and output freeze. With it clear, idle_in has no effect.
- R4: Control bits 2:0 select the mode. In mode 001 the output goes high at the first primary match. Mode 010 starts high and goes low at the first primary match. Mode 011 toggles at every primary match.
- R5: Mode 100 drives one pulse. The output goes high at the primary match, low at the next secondary match, and then stays low.
- R6: Mode 110 is PWM. The counter returns to zero on the tick where it equals the active secondary value. The output is high while the counter is below the active primary value.
- R7: In PWM, primary and secondary writes read back at once but become active only at rollover. In other modes they are active at once.
- R8: Fault enables are control bits 10:8 (A, B, C). Fault status is bits 13:11. In PWM, an enabled fault input sets its sticky status bit. Writing 1 to a status bit clears it. A disabled input has no effect.
- R9: While an enabled status bit is set in PWM the output is low. PWM resumes at the first rollover after the flags are clear and the enabled inputs are inactive.
- R10: Software writes bit 0 of address 3 to set or clear the trigger status. When control bit 3 is 1, the bit also clears on a counted secondary match. When control bit 3 is 0, only software changes it.
- R11: Any change of mode restarts the counter at zero. Mode 000 and the reserved modes 101 and 111 hold the counter at zero and the output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| ext_tick | input | NEXT | external tick strobes |
| idle_in | input | 1 | idle request |
| fault_in | input | 3 | fault inputs A, B, C (bits 0, 1, 2) |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 3 | write address |
| wr_data | input | DW | write data |
| rd_addr | input | 3 | read address |
| rd_data | output | DW | read data (combinational) |
| cmp_out | output | 1 | compare/PWM output |
| trig_stat | output | 1 | trigger status bit |

## Verification
The assertions check these properties on every cycle:
- the period wrap to zero in PWM;
- the counter freeze in idle;
- the low output under an active fault;
- that fault flags stay set until software clears them;
- that the trigger bit holds when auto-clear is off;
- that active compare values stay stable between rollovers;
- that the counter is held in the off state.

Some behaviours only the bench's scenarios can show: the exact cycle of each set, clear, toggle and pulse edge, the selection among tick sources, the recovery point after a fault, and the readback of buffered values. The bench shows them with a behavioural model that it compares against the outputs every clock.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_ARMED = 3'd1,
        ST_PULSE = 3'd2,
        ST_DONE  = 3'd3,
        ST_PWM   = 3'd4,
        ST_FAULT = 3'd5
    } ocp_state_e;

    localparam logic [2:0] MD_OFF = 3'b000;
    localparam logic [2:0] MD_SET = 3'b001;
    localparam logic [2:0] MD_CLR = 3'b010;
    localparam logic [2:0] MD_TGL = 3'b011;
    localparam logic [2:0] MD_ONE = 3'b100;
    localparam logic [2:0] MD_PWM = 3'b110;

    localparam logic [2:0] SEL_SYS = 3'b111;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_PRI  = 3'd1;
    localparam logic [2:0] A_SEC  = 3'd2;
    localparam logic [2:0] A_TRIG = 3'd3;
    localparam logic [2:0] A_CNT  = 3'd4;

    function automatic ocp_state_e entry_state(input logic [2:0] md);
        case (md)
            MD_SET, MD_CLR, MD_TGL, MD_ONE: return ST_ARMED;
            MD_PWM:                         return ST_PWM;
            default:                        return ST_OFF;
        endcase
    endfunction

endpackage

// File: rtl/ocp_tick_sel.sv
module ocp_tick_sel
    import ocp_pkg::*;
#(
    parameter int NEXT = 5
) (
    input  logic [2:0]      sel,
    input  logic [NEXT-1:0] ext_tick,
    input  logic            idle_in,
    input  logic            idle_stop,
    output logic            tick
);

    logic raw;

    always_comb begin
        raw = 1'b0;
        if (sel == SEL_SYS) begin
            raw = 1'b1;
        end else begin
            for (int i = 0; i < NEXT; i++) begin
                if (sel == 3'(i)) raw = ext_tick[i];
            end
        end
    end

    assign tick = raw & ~(idle_in & idle_stop);

endmodule

// File: rtl/ocp_regs.sv
module ocp_regs
    import ocp_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [2:0]    fault_in,
    input  logic          rollover,
    input  logic          sec_hit,
    output logic [2:0]    mode,
    output logic          trig_auto,
    output logic          idle_stop,
    output logic [2:0]    clk_sel,
    output logic [2:0]    fault_stat,
    output logic [CW-1:0] pri_act,
    output logic [CW-1:0] sec_act,
    output logic [CW-1:0] pri_buf,
    output logic [CW-1:0] sec_buf,
    output logic          trig_stat,
    output logic          fault_active,
    output logic          fault_live,
    output logic [DW-1:0] ctrl_word
);

    logic [2:0] fen;
    logic       is_pwm, wr_ctrl, wr_pri, wr_sec, wr_trig;

    assign is_pwm  = (mode == MD_PWM);
    assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
    assign wr_pri  = wr_en && (wr_addr == A_PRI);
    assign wr_sec  = wr_en && (wr_addr == A_SEC);
    assign wr_trig = wr_en && (wr_addr == A_TRIG);

    assign fault_active = |(fault_stat & fen);
    assign fault_live   = |(fault_in & fen);
    assign ctrl_word    = DW'({fault_stat, fen, clk_sel, idle_stop, trig_auto, mode});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode       <= MD_OFF;
            trig_auto  <= 1'b0;
            idle_stop  <= 1'b0;
            clk_sel    <= 3'b000;
            fen        <= 3'b000;
            fault_stat <= 3'b000;
            pri_act    <= '0;
            sec_act    <= '0;
            pri_buf    <= '0;
            sec_buf    <= '0;
            trig_stat  <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                mode      <= wr_data[2:0];
                trig_auto <= wr_data[3];
                idle_stop <= wr_data[4];
                clk_sel   <= wr_data[7:5];
                fen       <= wr_data[10:8];
            end
            fault_stat <= (fault_stat & ~(wr_ctrl ? wr_data[13:11] : 3'b000))
                        | (is_pwm ? (fault_in & fen) : 3'b000);
            if (wr_pri) pri_buf <= CW'(wr_data);
            if (wr_sec) sec_buf <= CW'(wr_data);
            if (rollover) begin
                pri_act <= pri_buf;
                sec_act <= sec_buf;
            end else if (!is_pwm) begin
                if (wr_pri) pri_act <= CW'(wr_data);
                if (wr_sec) sec_act <= CW'(wr_data);
            end
            if (wr_trig)                   trig_stat <= wr_data[0];
            else if (trig_auto && sec_hit) trig_stat <= 1'b0;
        end
    end

endmodule

// File: rtl/ocp_core.sv
module ocp_core
    import ocp_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    mode,
    input  logic          tick,
    input  logic [CW-1:0] pri_act,
    input  logic [CW-1:0] sec_act,
    input  logic          fault_active,
    input  logic          fault_live,
    output logic [CW-1:0] cnt,
    output logic          cmp_out,
    output logic          sec_hit,
    output logic          rollover,
    output logic          restart,
    output ocp_state_e    state
);

    ocp_state_e nxt;
    logic [2:0] mode_q;
    logic       out_q, running, pri_hit;

    assign restart  = (mode != mode_q);
    assign running  = (state != ST_OFF) && !restart && tick;
    assign pri_hit  = running && (cnt == pri_act);
    assign sec_hit  = running && (cnt == sec_act);
    assign rollover = sec_hit && (state == ST_PWM || state == ST_FAULT);

    always_comb begin
        nxt = state;
        if (restart) begin
            nxt = entry_state(mode);
        end else begin
            unique case (state)
                ST_OFF:   nxt = ST_OFF;
                ST_ARMED: if (pri_hit) begin
                              if (mode == MD_ONE)      nxt = ST_PULSE;
                              else if (mode != MD_TGL) nxt = ST_DONE;
                          end
                ST_PULSE: if (sec_hit) nxt = ST_DONE;
                ST_DONE:  nxt = ST_DONE;
                ST_PWM:   if (fault_active) nxt = ST_FAULT;
                ST_FAULT: if (!fault_active && !fault_live && sec_hit) nxt = ST_PWM;
                default:  nxt = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_OFF;
            mode_q <= MD_OFF;
        end else begin
            state  <= nxt;
            mode_q <= mode;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            out_q <= 1'b0;
        end else if (restart) begin
            cnt   <= '0;
            out_q <= (mode == MD_CLR);
        end else begin
            if (running) cnt <= rollover ? '0 : cnt + 1'b1;
            if (pri_hit && state == ST_ARMED) begin
                case (mode)
                    MD_SET, MD_ONE: out_q <= 1'b1;
                    MD_CLR:         out_q <= 1'b0;
                    MD_TGL:         out_q <= ~out_q;
                    default:        out_q <= out_q;
                endcase
            end
            if (sec_hit && state == ST_PULSE) out_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (state)
            ST_PWM:           cmp_out = (cnt < pri_act) && !fault_active;
            ST_OFF, ST_FAULT: cmp_out = 1'b0;
            default:          cmp_out = out_q;
        endcase
    end

endmodule

// File: rtl/ocpwm_unit.sv
module ocpwm_unit
    import ocp_pkg::*;
#(
    parameter int DW   = 16,
    parameter int CW   = 16,
    parameter int NEXT = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NEXT-1:0] ext_tick,
    input  logic            idle_in,
    input  logic [2:0]      fault_in,
    input  logic            wr_en,
    input  logic [2:0]      wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic [2:0]      rd_addr,
    output logic [DW-1:0]   rd_data,
    output logic            cmp_out,
    output logic            trig_stat
);

    logic [2:0]    mode, clk_sel, fault_stat;
    logic          trig_auto, idle_stop, tick, sec_hit, rollover, restart;
    logic          fault_active, fault_live;
    logic [CW-1:0] pri_act, sec_act, pri_buf, sec_buf, cnt;
    logic [DW-1:0] ctrl_word;
    ocp_state_e    state;

    ocp_tick_sel #(.NEXT(NEXT)) u_tick (
        .sel(clk_sel), .ext_tick(ext_tick), .idle_in(idle_in),
        .idle_stop(idle_stop), .tick(tick)
    );

    ocp_regs #(.DW(DW), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .fault_in(fault_in), .rollover(rollover),
        .sec_hit(sec_hit), .mode(mode), .trig_auto(trig_auto),
        .idle_stop(idle_stop), .clk_sel(clk_sel), .fault_stat(fault_stat),
        .pri_act(pri_act), .sec_act(sec_act), .pri_buf(pri_buf),
        .sec_buf(sec_buf), .trig_stat(trig_stat), .fault_active(fault_active),
        .fault_live(fault_live), .ctrl_word(ctrl_word)
    );

    ocp_core #(.CW(CW)) u_core (
        .clk(clk), .rst_n(rst_n), .mode(mode), .tick(tick),
        .pri_act(pri_act), .sec_act(sec_act), .fault_active(fault_active),
        .fault_live(fault_live), .cnt(cnt), .cmp_out(cmp_out),
        .sec_hit(sec_hit), .rollover(rollover), .restart(restart),
        .state(state)
    );

    always_comb begin
        case (rd_addr)
            A_CTRL:  rd_data = ctrl_word;
            A_PRI:   rd_data = DW'(pri_buf);
            A_SEC:   rd_data = DW'(sec_buf);
            A_TRIG:  rd_data = DW'(trig_stat);
            A_CNT:   rd_data = DW'(cnt);
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/ocpwm_unit_chk.sv
module ocpwm_unit_chk
    import ocp_pkg::*;
#(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          idle_in,
    input logic          idle_stop,
    input logic          tick,
    input logic          restart,
    input ocp_state_e    state,
    input logic [2:0]    mode,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] pri_act,
    input logic [CW-1:0] sec_act,
    input logic          rollover,
    input logic          fault_active,
    input logic [2:0]    fault_stat,
    input logic          cmp_out,
    input logic          wr_en,
    input logic [2:0]    wr_addr,
    input logic          trig_auto,
    input logic          trig_stat
);

    // R6
    pwm_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PWM && tick && !restart && cnt == sec_act) |=> (cnt == '0));

    // R3
    idle_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_in && idle_stop && !restart) |=> $stable(cnt));

    // R9
    fault_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_PWM || state == ST_FAULT) && fault_active) |-> !cmp_out);

    // R8
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == A_CTRL) |=> ((fault_stat & $past(fault_stat)) == $past(fault_stat)));

    // R10
    trig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_auto && !(wr_en && wr_addr == A_TRIG)) |=> $stable(trig_stat));

    // R11
    off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && !restart) |=> (cnt == '0));

    // R7
    buffer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PWM && mode == MD_PWM && !rollover) |=> ($stable(pri_act) && $stable(sec_act)));

endmodule

bind ocpwm_unit ocpwm_unit_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .idle_in(idle_in), .idle_stop(idle_stop),
    .tick(tick), .restart(restart), .state(state), .mode(mode), .cnt(cnt),
    .pri_act(pri_act), .sec_act(sec_act), .rollover(rollover),
    .fault_active(fault_active), .fault_stat(fault_stat), .cmp_out(cmp_out),
    .wr_en(wr_en), .wr_addr(wr_addr), .trig_auto(trig_auto),
    .trig_stat(trig_stat)
);

// File: tb/ocpwm_unit_test.sv
`timescale 1ns/100ps
module ocpwm_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  ext_tick = '0;
    logic        idle_in = 1'b0;
    logic [2:0]  fault_in = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        cmp_out, trig_stat;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    rot_en = 1'b1;
    bit    done = 1'b0;

    always #4 clk = ~clk;

    ocpwm_unit uut (
        .clk(clk), .rst_n(rst_n), .ext_tick(ext_tick), .idle_in(idle_in),
        .fault_in(fault_in), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cmp_out(cmp_out), .trig_stat(trig_stat)
    );

    // behavioural reference model
    logic [15:0] m_ctrl = '0, m_pri_b = '0, m_sec_b = '0;
    logic [15:0] m_pri_a = '0, m_sec_a = '0, m_cnt = '0;
    logic [2:0]  m_prev = '0;
    bit          m_trig = 0, m_out = 0;
    int          m_ph = 0;   // 0 off 1 armed 2 pulse 3 done 4 pwm 5 fault

    function automatic int entry_of(logic [2:0] md);
        if (md >= 3'd1 && md <= 3'd4) return 1;
        if (md == 3'd6) return 4;
        return 0;
    endfunction

    always @(posedge clk) begin : model
        logic [2:0] md, sel, st, en;
        bit tk, rs, fa, live, ph_h, sh, roll, au;
        if (!rst_n) begin
            m_ctrl = '0; m_pri_b = '0; m_sec_b = '0; m_pri_a = '0; m_sec_a = '0;
            m_cnt = '0; m_prev = '0; m_trig = 0; m_out = 0; m_ph = 0;
        end else begin
            md = m_ctrl[2:0]; sel = m_ctrl[7:5]; en = m_ctrl[10:8];
            st = m_ctrl[13:11]; au = m_ctrl[3];
            if (sel == 3'd7) tk = 1;
            else if (sel <= 3'd4) tk = ext_tick[sel];
            else tk = 0;
            if (idle_in && m_ctrl[4]) tk = 0;
            rs = (md != m_prev);
            fa = |(st & en);
            live = |(fault_in & en);
            ph_h = tk && !rs && m_ph != 0 && m_cnt == m_pri_a;
            sh = tk && !rs && m_ph != 0 && m_cnt == m_sec_a;
            roll = sh && m_ph >= 4;
            if (rs) begin
                m_cnt = '0; m_ph = entry_of(md); m_out = (md == 3'd2); m_prev = md;
            end else begin
                if (tk && m_ph != 0) m_cnt = roll ? 16'd0 : m_cnt + 16'd1;
                case (m_ph)
                    1: if (ph_h) begin
                           if (md == 3'd1) begin m_out = 1; m_ph = 3; end
                           else if (md == 3'd2) begin m_out = 0; m_ph = 3; end
                           else if (md == 3'd3) m_out = !m_out;
                           else begin m_out = 1; m_ph = 2; end
                       end
                    2: if (sh) begin m_out = 0; m_ph = 3; end
                    4: if (fa) m_ph = 5;
                    5: if (!fa && !live && sh) m_ph = 4;
                    default: ;
                endcase
            end
            if (roll) begin m_pri_a = m_pri_b; m_sec_a = m_sec_b; end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: begin m_ctrl[10:0] = wr_data[10:0]; st = st & ~wr_data[13:11]; end
                    3'd1: begin m_pri_b = wr_data; if (md != 3'd6) m_pri_a = wr_data; end
                    3'd2: begin m_sec_b = wr_data; if (md != 3'd6) m_sec_a = wr_data; end
                    3'd3: m_trig = wr_data[0];
                    default: ;
                endcase
            end
            if (md == 3'd6) st = st | (fault_in & en);
            m_ctrl[13:11] = st;
            if (!(wr_en && wr_addr == 3'd3) && au && sh) m_trig = 0;
        end
    end

    function automatic bit exp_out();
        bit fa;
        fa = |(m_ctrl[13:11] & m_ctrl[10:8]);
        case (m_ph)
            4:       return (m_cnt < m_pri_a) && !fa;
            0, 5:    return 0;
            default: return m_out;
        endcase
    endfunction

    function automatic logic [15:0] exp_rd(logic [2:0] a);
        case (a)
            3'd0:    return {2'b00, m_ctrl[13:0]};
            3'd1:    return m_pri_b;
            3'd2:    return m_sec_b;
            3'd3:    return {15'd0, m_trig};
            3'd4:    return m_cnt;
            default: return 16'd0;
        endcase
    endfunction

    task automatic chk(string req, string what, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %h exp %h", req, what, got, exp);
        end
    endtask

    // per-cycle comparison against the model
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rot_en) rd_addr = (rd_addr >= 3'd4) ? 3'd0 : rd_addr + 3'd1;
            #2;
            chk(cur_req, "cmp_out", {15'd0, cmp_out}, {15'd0, exp_out()});
            chk(cur_req, "rd_data", rd_data, exp_rd(rd_addr));
            chk(cur_req, "trig_stat", {15'd0, trig_stat}, {15'd0, m_trig});
        end
    end

    function automatic logic [15:0] mk(logic [2:0] md, bit au, bit is, logic [2:0] sel, logic [2:0] en);
        return {2'b00, 3'b000, en, sel, is, au, md};
    endfunction

    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic peek(logic [2:0] a, logic [15:0] exp, string req);
        @(negedge clk);
        rot_en = 1'b0; rd_addr = a;
        #2;
        chk(req, "peek", rd_data, exp);
        rot_en = 1'b1;
    endtask

    task automatic chk_out(bit exp, string req);
        @(negedge clk);
        #2;
        chk(req, "out", {15'd0, cmp_out}, {15'd0, exp});
    endtask

    task automatic pulse_ext(int idx);
        @(negedge clk);
        ext_tick = 5'(1 << idx);
        @(negedge clk);
        ext_tick = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        cur_req = "R1";
        peek(3'd0, 16'h0000, "R1");
        peek(3'd4, 16'h0000, "R1");
        chk_out(1'b0, "R1");
        wr(3'd0, 16'hC000);
        peek(3'd0, 16'h0000, "R1");

        cur_req = "R4";
        wr(3'd1, 16'd5);
        wr(3'd0, mk(3'd1, 0, 0, 3'd7, 3'd0));
        run(12);
        chk_out(1'b1, "R4");
        wr(3'd0, mk(3'd2, 0, 0, 3'd7, 3'd0));
        run(2);
        chk_out(1'b1, "R4");
        run(10);
        chk_out(1'b0, "R4");

        cur_req = "R2";
        wr(3'd1, 16'd3);
        wr(3'd0, mk(3'd3, 0, 0, 3'd2, 3'd0));
        run(1);
        for (int i = 0; i < 5; i++) pulse_ext(0);
        peek(3'd4, 16'd0, "R2");
        for (int i = 0; i < 4; i++) pulse_ext(2);
        peek(3'd4, 16'd4, "R2");
        chk_out(1'b1, "R2");
        wr(3'd0, mk(3'd3, 0, 0, 3'd5, 3'd0));
        run(5);
        peek(3'd4, 16'd4, "R2");

        cur_req = "R3";
        idle_in = 1'b1;
        wr(3'd0, mk(3'd3, 0, 1, 3'd7, 3'd0));
        run(6);
        peek(3'd4, 16'd4, "R3");
        wr(3'd0, mk(3'd3, 0, 0, 3'd7, 3'd0));
        run(6);
        idle_in = 1'b0;
        run(4);

        cur_req = "R5";
        wr(3'd2, 16'd12);
        wr(3'd1, 16'd4);
        wr(3'd0, mk(3'd4, 0, 0, 3'd7, 3'd0));
        run(40);
        chk_out(1'b0, "R5");

        cur_req = "R11";
        wr(3'd0, mk(3'd0, 0, 0, 3'd7, 3'd0));
        run(3);
        peek(3'd4, 16'd0, "R11");
        chk_out(1'b0, "R11");
        wr(3'd0, mk(3'd5, 0, 0, 3'd7, 3'd0));
        run(5);
        peek(3'd4, 16'd0, "R11");

        cur_req = "R6";
        wr(3'd1, 16'd3);
        wr(3'd2, 16'd9);
        wr(3'd0, mk(3'd6, 0, 0, 3'd7, 3'b001));
        run(25);
        cur_req = "R7";
        wr(3'd1, 16'd6);
        peek(3'd1, 16'd6, "R7");
        run(30);

        cur_req = "R8";
        fault_in = 3'b010;
        run(5);
        peek(3'd0, mk(3'd6, 0, 0, 3'd7, 3'b001), "R8");
        fault_in = 3'b001;
        run(1);
        fault_in = 3'b000;
        run(3);
        peek(3'd0, mk(3'd6, 0, 0, 3'd7, 3'b001) | 16'h0800, "R8");
        cur_req = "R9";
        chk_out(1'b0, "R9");
        run(12);
        wr(3'd0, mk(3'd6, 0, 0, 3'd7, 3'b001) | 16'h0800);
        run(25);

        cur_req = "R10";
        wr(3'd3, 16'd1);
        run(30);
        peek(3'd3, 16'd1, "R10");
        wr(3'd0, mk(3'd6, 1, 0, 3'd7, 3'b001));
        run(15);
        peek(3'd3, 16'd0, "R10");
        wr(3'd0, mk(3'd6, 0, 0, 3'd7, 3'b001));
        wr(3'd3, 16'd1);
        wr(3'd3, 16'd0);
        peek(3'd3, 16'd0, "R10");
        run(5);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL %s watchdog expired", cur_req);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule